// File: doc/BRIEF.md
# Sleep and MPS Pulse Controller

This block handles the low-power states of a powered-device front end. A falling edge on the active-low sleep request moves the block from normal operation into one of two sleep states. The level of the active-low ultra-low-power select is taken at the moment of that edge and decides which state is entered. A falling edge on the active-low wake request returns the block to normal operation from either sleep state. While the block is asleep, the power-good signal passed to the downstream converter is held low. The isolation switch is not controlled here and stays on in every state.

In both sleep states the block drives a periodic enable for the LED current source. The enable has a 25% duty cycle, and a parameter chooses between a slow rate of 250 Hz and a fast rate of 15.625 kHz. In the ultra-low-power state a second, much slower schedule switches an internal load on for about 84 ms and then off for about 228 ms, over and over. This keeps enough current flowing to hold the maintain-power-signature. A thermal-shutdown input blanks the LED enable. All periods are counted in clock cycles derived from the clock frequency parameter.

Top module: `sleep_mps_ctrl`

## Requirements
- R1: During and right after synchronous reset the block is awake: sleep_active, ulp_active, led_en and mps_load_en are 0, and pg_out follows pg_in.
- R2: A 1-to-0 transition of sl_n while awake, with ulp_n sampled high, enters normal sleep (sleep_active=1, ulp_active=0). The state shows at the outputs after the third rising clock edge that follows the input change.
- R3: A 1-to-0 transition of sl_n while awake, with ulp_n sampled low at the same time, enters ultra-low-power sleep (sleep_active=1, ulp_active=1), with the same latency as R2.
- R4: Changes of ulp_n while the block is asleep have no effect on the state or on any output.
- R5: A 1-to-0 transition of wk_n returns the block to awake from either sleep state, with the same latency as R2. led_en and mps_load_en then read 0.
- R6: When the synchronised sl_n and wk_n falling edges land in the same cycle, wake wins and the block is awake afterwards.
- R7: pg_out equals pg_in while awake and is 0 in both sleep states.
- R8: In either sleep state, led_en (without thermal shutdown) repeats with a period of LED_PERIOD cycles. It is high for the first LED_PERIOD/4 cycles of each period, counting from the first cycle the sleep state is visible. LED_PERIOD is CLK_HZ/15625 when LED_FAST=1 and CLK_HZ/250 otherwise.
- R9: In ultra-low-power sleep, mps_load_en is high for the MPS_ON_US-derived cycle count and then low for the MPS_OFF_US-derived count, repeating from the first visible cycle. It is 0 in normal sleep and while awake.
- R10: While thermal_hot is 1, led_en is 0. The LED schedule keeps running underneath, so led_en resumes in phase when thermal_hot clears.
- R11: A further sl_n falling edge while already asleep is ignored: the state and the phase of both schedules are unchanged.
- R12: Rising edges of sl_n and wk_n have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sl_n | input | 1 | Sleep request, falling edge enters sleep (asynchronous) |
| wk_n | input | 1 | Wake request, falling edge leaves sleep (asynchronous) |
| ulp_n | input | 1 | Low selects ultra-low-power sleep at the sleep edge (asynchronous) |
| thermal_hot | input | 1 | Thermal shutdown active, blanks the LED enable |
| pg_in | input | 1 | Power-good from the hot-swap path |
| pg_out | output | 1 | Power-good to the downstream converter, forced low in sleep |
| led_en | output | 1 | LED current pulse enable |
| mps_load_en | output | 1 | Internal signature load enable |
| sleep_active | output | 1 | High in either sleep state |
| ulp_active | output | 1 | High in ultra-low-power sleep |

## Verification
The hardest cases to reach are the ones where control edges arrive while the block is already asleep. Examples are a second sleep edge, or ulp_n toggling mid-way through a long load schedule. These must leave the LED and load phases untouched, and that can only be seen by running the schedules across their wrap points. The bench therefore holds each sleep state for a random number of cycles, up to more than one full load period. Every cycle it scrambles sl_n, ulp_n, thermal_hot and pg_in, and compares each output with a cycle index counted from entry. Separate directed steps drive sleep and wake edges into the same cycle, and wake from both sleep states.

// File: rtl/sleep_mps_pkg.sv
package sleep_mps_pkg;

    typedef enum logic [1:0] {
        MODE_AWAKE = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_ULP   = 2'd2
    } pd_mode_e;

    typedef struct packed {
        logic sleep_fall;
        logic wake_fall;
        logic ulp_low;
    } ctrl_evt_t;

    localparam int unsigned LED_HZ_SLOW  = 250;
    localparam int unsigned LED_HZ_FAST  = 15625;
    localparam int unsigned LED_DUTY_DIV = 4;
    localparam int unsigned SYNC_STAGES  = 2;
    localparam int unsigned CTRL_LINES   = 3;
    localparam int unsigned LINE_SL      = 0;
    localparam int unsigned LINE_WK      = 1;
    localparam int unsigned LINE_ULP     = 2;

    function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned us);
        longint unsigned t;
        t = (longint'(clk_hz) * longint'(us)) / 64'd1000000;
        if (t == 0) t = 1;
        return int'(t);
    endfunction

    function automatic int unsigned led_period_cycles(input int unsigned clk_hz,
                                                      input bit fast);
        int unsigned p;
        p = clk_hz / (fast ? LED_HZ_FAST : LED_HZ_SLOW);
        if (p < LED_DUTY_DIV) p = LED_DUTY_DIV;
        return p;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned period);
        return (period < 2) ? 1 : $clog2(period + 1);
    endfunction

endpackage

// File: rtl/slp_sync_fall.sv
module slp_sync_fall
    import sleep_mps_pkg::*;
#(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(STAGES); k++) stg[k] <= '1;
            prev <= '1;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
            prev <= stg[STAGES-1];
        end
    end

    assign level = stg[STAGES-1];
    assign fall  = prev & ~level;

endmodule

// File: rtl/slp_mode_fsm.sv
module slp_mode_fsm
    import sleep_mps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctrl_evt_t evt,
    output pd_mode_e  mode
);
    pd_mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        if (evt.wake_fall) begin
            mode_nx = MODE_AWAKE;
        end else if (evt.sleep_fall && mode == MODE_AWAKE) begin
            mode_nx = evt.ulp_low ? MODE_ULP : MODE_SLEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_AWAKE;
        else     mode <= mode_nx;
    end

    // R6: a wake edge always leaves the block awake, even with a sleep edge beside it
    a_r6_wake_wins: assert property (@(posedge clk) disable iff (rst)
        evt.wake_fall |=> mode == MODE_AWAKE);

    // R3: sleep edge with the select low lands in ultra-low-power sleep
    a_r3_ulp_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_AWAKE && evt.sleep_fall && !evt.wake_fall && evt.ulp_low)
        |=> mode == MODE_ULP);

    // R2: sleep edge with the select high lands in normal sleep
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_AWAKE && evt.sleep_fall && !evt.wake_fall && !evt.ulp_low)
        |=> mode == MODE_SLEEP);

    // R11: once asleep, only a wake edge moves the state
    a_r11_asleep_holds: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_AWAKE && !evt.wake_fall) |=> $stable(mode));

endmodule

// File: rtl/slp_duty_timer.sv
module slp_duty_timer
    import sleep_mps_pkg::*;
#(
    parameter int unsigned PERIOD   = 64,
    parameter int unsigned HIGH_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic active
);
    localparam int unsigned CW = cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign active = en && (32'(cnt) < HIGH_CYC);

    // R8: the phase counter never leaves its period
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < PERIOD);

    // R9: a running schedule only returns to zero from the last cycle of its period
    a_r9_wrap_point: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && cnt == '0) |-> $past(cnt) == LAST);

endmodule

// File: rtl/sleep_mps_ctrl.sv
module sleep_mps_ctrl
    import sleep_mps_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 25_000_000,
    parameter bit          LED_FAST   = 1'b0,
    parameter int unsigned MPS_ON_US  = 84_000,
    parameter int unsigned MPS_OFF_US = 228_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sl_n,
    input  logic wk_n,
    input  logic ulp_n,
    input  logic thermal_hot,
    input  logic pg_in,
    output logic pg_out,
    output logic led_en,
    output logic mps_load_en,
    output logic sleep_active,
    output logic ulp_active
);
    localparam int unsigned LED_PERIOD = led_period_cycles(CLK_HZ, LED_FAST);
    localparam int unsigned LED_HIGH   = LED_PERIOD / LED_DUTY_DIV;
    localparam int unsigned MPS_ON     = us_to_cycles(CLK_HZ, MPS_ON_US);
    localparam int unsigned MPS_PERIOD = MPS_ON + us_to_cycles(CLK_HZ, MPS_OFF_US);

    logic [CTRL_LINES-1:0] raw_lines;
    logic [CTRL_LINES-1:0] sync_level;
    logic [CTRL_LINES-1:0] sync_fall;
    ctrl_evt_t             evt;
    pd_mode_e              mode;
    logic                  led_run, mps_run, led_phase;

    assign raw_lines[LINE_SL]  = sl_n;
    assign raw_lines[LINE_WK]  = wk_n;
    assign raw_lines[LINE_ULP] = ulp_n;

    slp_sync_fall #(.W(CTRL_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (raw_lines),
        .level (sync_level),
        .fall  (sync_fall)
    );

    assign evt.sleep_fall = sync_fall[LINE_SL];
    assign evt.wake_fall  = sync_fall[LINE_WK];
    assign evt.ulp_low    = ~sync_level[LINE_ULP];

    slp_mode_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .mode (mode)
    );

    assign led_run = (mode != MODE_AWAKE);
    assign mps_run = (mode == MODE_ULP);

    slp_duty_timer #(.PERIOD(LED_PERIOD), .HIGH_CYC(LED_HIGH)) u_led_tmr (
        .clk    (clk),
        .rst    (rst),
        .en     (led_run),
        .active (led_phase)
    );

    slp_duty_timer #(.PERIOD(MPS_PERIOD), .HIGH_CYC(MPS_ON)) u_mps_tmr (
        .clk    (clk),
        .rst    (rst),
        .en     (mps_run),
        .active (mps_load_en)
    );

    assign led_en       = led_phase & ~thermal_hot;
    assign pg_out       = pg_in & (mode == MODE_AWAKE);
    assign sleep_active = led_run;
    assign ulp_active   = mps_run;

    // R12: a reported edge always corresponds to a line that now reads low
    for (genvar g = 0; g < CTRL_LINES; g++) begin : g_edge_chk
        a_r12_fall_level: assert property (@(posedge clk) disable iff (rst)
            sync_fall[g] |-> !sync_level[g]);
    end

    // R7: power-good never reaches the converter while asleep
    a_r7_pg_low_asleep: assert property (@(posedge clk) disable iff (rst)
        sleep_active |-> !pg_out);

    // R10: a hot die never sees an LED pulse
    a_r10_thermal_blank: assert property (@(posedge clk) disable iff (rst)
        thermal_hot |-> !led_en);

    // R9: the signature load only runs in ultra-low-power sleep
    a_r9_mps_only_ulp: assert property (@(posedge clk) disable iff (rst)
        mps_load_en |-> ulp_active);

    // R5: leaving sleep stops both pulse outputs on the next cycle
    a_r5_wake_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_active) |-> (!led_en && !mps_load_en));

endmodule

// File: tb/tb_sleep_mps_ctrl.sv
module tb_sleep_mps_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 1_000_000;
    localparam int LED_P      = 64;    // 1 MHz / 15.625 kHz
    localparam int LED_H      = 16;
    localparam int MPS_ON     = 840;
    localparam int MPS_OFF    = 2280;
    localparam int MPS_P      = MPS_ON + MPS_OFF;

    logic clk = 1'b0;
    logic rst, sl_n, wk_n, ulp_n, thermal_hot, pg_in;
    logic pg_out, led_en, mps_load_en, sleep_active, ulp_active;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_mps_ctrl #(
        .CLK_HZ(TB_CLK_HZ), .LED_FAST(1'b1),
        .MPS_ON_US(MPS_ON), .MPS_OFF_US(MPS_OFF)
    ) dut (
        .clk(clk), .rst(rst), .sl_n(sl_n), .wk_n(wk_n), .ulp_n(ulp_n),
        .thermal_hot(thermal_hot), .pg_in(pg_in), .pg_out(pg_out),
        .led_en(led_en), .mps_load_en(mps_load_en),
        .sleep_active(sleep_active), .ulp_active(ulp_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic bit exp_led(input int idx, input bit hot);
        return ((idx % LED_P) < LED_H) && !hot;
    endfunction

    function automatic bit exp_mps(input bit ulp, input int idx);
        return ulp && ((idx % MPS_P) < MPS_ON);
    endfunction

    task automatic settle_lines();
        sl_n = 1'b1; wk_n = 1'b1; ulp_n = 1'b1; thermal_hot = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // drive the sleep edge, leave at the negedge of the first visible cycle
    task automatic enter_sleep(input bit ulp);
        ulp_n = ~ulp;
        sl_n  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_sleep(input bit ulp, input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            chk(thermal_hot ? "R10 led_en" : "R8 led_en", led_en, exp_led(i, thermal_hot));
            chk(ulp ? "R9 mps_load_en" : "R9 mps idle in normal sleep", mps_load_en, exp_mps(ulp, i));
            chk("R11 sleep_active held", sleep_active, 1);
            chk(ulp ? "R3 ulp_active" : "R4 ulp_active stays 0", ulp_active, ulp);
            chk("R7 pg_out low in sleep", pg_out, 0);
            if (i < ncyc - 5) sl_n = 1'($urandom);
            else              sl_n = 1'b1;
            ulp_n       = 1'($urandom);
            thermal_hot = (($urandom % 4) == 0);
            pg_in       = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic wake_up();
        thermal_hot = 1'b0;
        wk_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 awake after wake edge", sleep_active, 0);
        chk("R5 ulp cleared", ulp_active, 0);
        chk("R5 led_en off", led_en, 0);
        chk("R5 mps off", mps_load_en, 0);
        chk("R7 pg_out follows", pg_out, pg_in);
        wk_n = 1'b1; sl_n = 1'b1; ulp_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R12 rising edges ignored", sleep_active, 0);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5981));
        rst = 1'b1; sl_n = 1'b1; wk_n = 1'b1; ulp_n = 1'b1;
        thermal_hot = 1'b0; pg_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset sleep_active", sleep_active, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sleep_active", sleep_active, 0);
        chk("R1 ulp_active", ulp_active, 0);
        chk("R1 led_en", led_en, 0);
        chk("R1 mps_load_en", mps_load_en, 0);
        chk("R1 pg_out", pg_out, 1);

        for (int i = 0; i < 20; i++) begin
            pg_in = 1'($urandom);
            @(negedge clk);
            chk("R7 pg_out awake", pg_out, pg_in);
        end
        pg_in = 1'b1;

        // edge latency: state must not show after only two edges
        ulp_n = 1'b1; sl_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet asleep after two edges", sleep_active, 0);
        @(negedge clk);
        chk("R2 normal sleep entered", sleep_active, 1);
        chk("R2 ulp_active", ulp_active, 0);
        wake_up();
        settle_lines();

        enter_sleep(1'b0);
        run_sleep(1'b0, 300);
        wake_up();
        settle_lines();

        enter_sleep(1'b1);
        run_sleep(1'b1, MPS_P + 300);
        wake_up();
        settle_lines();

        // simultaneous sleep and wake edges
        ulp_n = 1'b0; sl_n = 1'b0; wk_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 wake wins", sleep_active, 0);
        repeat (6) @(negedge clk);
        chk("R6 still awake", sleep_active, 0);
        chk("R6 no load", mps_load_en, 0);
        settle_lines();

        for (int t = 0; t < 8; t++) begin
            bit u;
            int n;
            u = 1'($urandom);
            n = 100 + int'($urandom % 3400);
            pg_in = 1'($urandom);
            enter_sleep(u);
            run_sleep(u, n);
            wake_up();
            settle_lines();
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule